// File: doc/BRIEF.md
# Chained Single-Precision Multiply and Add Slice

This block is one slice of a cascade of identical slices. Each slice carries two independent single-precision floating-point units. The multiplier forms the product of two local operands and drives it onto a dedicated chain output, which the next slice takes as its chain input. The adder combines a third local operand with the chain input from the previous slice. It adds or subtracts according to a per-operation configuration. It can also ignore the chain and pass the local operand through untouched.

Both units round to nearest, with ties going to even. Subnormals are flushed to signed zero. Each unit keeps its own four exception flags, and those flags are registered together with the value they describe. Operands are captured in an input register bank and pass through two internal pipeline stages (align, then normalize) before the rounded values land in the output register bank. A valid bit travels through the pipeline in step with the data.

Top module: `fpslice_chain`

## Requirements
- R1: `chainOut` carries the product `mulA * mulB`, rounded to nearest-even, whatever the chain-enable and subtract settings are.
- R2: With `cfgChainEn` low, `result` is bit-for-bit equal to `addA` for any value of `cfgSubtract` and `chainIn`. `addFlags` is zero unless `addA` is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), in which case only the invalid flag is set.
- R3: With `cfgChainEn` high and `cfgSubtract` low, `result` is `addA + chainIn` rounded to nearest-even.
- R4: With `cfgChainEn` high and `cfgSubtract` high, `result` is `addA - chainIn`, with `chainIn` as the subtrahend.
- R5: When operands are sampled on a rising edge with `inValid` high, the matching `chainOut`, `result`, flags and a high `outValid` appear after the third rising edge that follows. Back-to-back operations are accepted every cycle.
- R6: A NaN operand, infinity times zero, or a sum of opposite infinities yields 0x7FC00000 with the invalid flag set. Infinity combined with a finite value yields the correctly signed infinity with no flag.
- R7: A rounded result above the largest finite value yields a signed infinity with the overflow and inexact flags set.
- R8: An operand with a zero exponent field is treated as a signed zero and raises no flag. A nonzero result below the smallest normal is replaced by a signed zero with the underflow and inexact flags set.
- R9: The inexact flag is set exactly when rounding discards nonzero bits. A tie rounds to the even significand.
- R10: Synchronous reset clears `outValid`, both data outputs and all flags to zero. While no new result arrives, the outputs hold their last value.
- R11: An exact zero difference of equal operands is +0. The sum of two negative zeros is -0.
- Flag vectors are ordered as bit 3 invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact (applies to R2, R6-R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and configuration present this cycle |
| cfgChainEn | input | 1 | Use the chain input in the adder |
| cfgSubtract | input | 1 | Subtract the chain input instead of adding it |
| mulA | input | 32 | Multiplier operand |
| mulB | input | 32 | Multiplier operand |
| addA | input | 32 | Local adder operand |
| chainIn | input | 32 | Chain input from the previous slice |
| chainOut | output | 32 | Product, to the next slice |
| result | output | 32 | Adder result |
| mulFlags | output | 4 | Multiplier flags {invalid, overflow, underflow, inexact} |
| addFlags | output | 4 | Adder flags {invalid, overflow, underflow, inexact} |
| outValid | output | 1 | Outputs hold a new result this cycle |

## Verification
The hardest cases to reach from the ports are those that decide a result in the last rounding step. These are a tie that must round up to the even value, a carry out of rounding that pushes the exponent to overflow, and a cancellation that lands below the normal range so that it gets flushed. The stimulus uses hand-picked operand pairs whose exact sums and products sit exactly on these boundaries, such as 1+2^-23 plus 2^-24, twice the largest finite value, and two adjacent smallest normals subtracted. These are issued back-to-back and mixed with passthrough and special-value operations, so that every pipeline stage holds a different case at the same time.

// File: rtl/fpslice_pkg.sv
package fpslice_pkg;
  localparam int FRAC_W  = 23;
  localparam int EXP_W   = 8;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int PROD_W  = 2 * MANT_W;
  localparam int EXT_W   = MANT_W + 3;
  localparam int SUM_W   = EXT_W + 1;
  localparam int XEXP_W  = EXP_W + 4;
  localparam int ALIGN_W = MANT_W + EXT_W - 1;
  localparam int ALIGN_CAP = ALIGN_W - 1;
  localparam int SH_W    = $clog2(ALIGN_W);
  localparam int LZ_W    = $clog2(EXT_W + 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

  localparam logic signed [XEXP_W-1:0] EXP_TOP = XEXP_W'(EXP_MAX);
  localparam logic signed [XEXP_W-1:0] BIAS_X  = XEXP_W'(BIAS);
  localparam logic signed [XEXP_W-1:0] ONE_X   = XEXP_W'(1);
  localparam logic signed [XEXP_W-1:0] ZERO_X  = '0;
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {K_NUM, K_ZERO, K_INF, K_NAN, K_PASS} kind_t;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } flags_t;

  // strobes from control to datapath: load enables per register bank
  typedef struct packed {
    logic ldIn;
    logic ldAlign;
    logic ldNorm;
    logic ldOut;
  } stageCtl_t;

  typedef struct packed {
    kind_t                     kind;
    logic                      sign;
    logic signed [XEXP_W-1:0]  exp;
    logic [PROD_W-1:0]         prod;
  } mulAlign_t;

  typedef struct packed {
    kind_t                     kind;
    logic                      sign;
    logic signed [XEXP_W-1:0]  exp;
    logic [SUM_W-1:0]          sum;
    logic [WORD_W-1:0]         word;
    logic                      passInv;
  } addAlign_t;

  typedef struct packed {
    kind_t                     kind;
    logic                      sign;
    logic signed [XEXP_W-1:0]  exp;
    logic [MANT_W-1:0]         mant;
    logic                      grd;
    logic                      stk;
    logic [WORD_W-1:0]         word;
    logic                      passInv;
  } normRec_t;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    flags_t            flags;
  } outRec_t;

  function automatic logic [EXP_W-1:0] expOf(input logic [WORD_W-1:0] w);
    return w[WORD_W-2:FRAC_W];
  endfunction

  function automatic logic [FRAC_W-1:0] fracOf(input logic [WORD_W-1:0] w);
    return w[FRAC_W-1:0];
  endfunction

  function automatic logic isNan(input logic [WORD_W-1:0] w);
    return (&expOf(w)) && (|fracOf(w));
  endfunction

  function automatic logic isInf(input logic [WORD_W-1:0] w);
    return (&expOf(w)) && !(|fracOf(w));
  endfunction

  function automatic logic isFlushZero(input logic [WORD_W-1:0] w);
    return !(|expOf(w));
  endfunction

  function automatic logic isSnan(input logic [WORD_W-1:0] w);
    return isNan(w) && !w[FRAC_W-1];
  endfunction

  function automatic logic [LZ_W-1:0] lzc(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) n = LZ_W'(EXT_W - 1 - i);
    return n;
  endfunction

  // round to nearest-even, then range check with flush-to-zero
  function automatic outRec_t finishRec(input normRec_t n);
    outRec_t                  o;
    logic [MANT_W:0]          m;
    logic signed [XEXP_W-1:0] e;
    logic                     up;
    o = '0;
    case (n.kind)
      K_ZERO: o.word = {n.sign, {(WORD_W-1){1'b0}}};
      K_INF:  o.word = {n.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      K_NAN: begin
        o.word = QNAN;
        o.flags.invalid = 1'b1;
      end
      K_PASS: begin
        o.word = n.word;
        o.flags.invalid = n.passInv;
      end
      default: begin
        up = n.grd & (n.stk | n.mant[0]);
        m  = {1'b0, n.mant} + (MANT_W+1)'(up);
        e  = n.exp;
        if (m[MANT_W]) begin
          m = m >> 1;
          e = e + ONE_X;
        end
        if (e >= EXP_TOP) begin
          o.word = {n.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          o.flags.overflow = 1'b1;
          o.flags.inexact  = 1'b1;
        end else if (e <= ZERO_X) begin
          o.word = {n.sign, {(WORD_W-1){1'b0}}};
          o.flags.underflow = 1'b1;
          o.flags.inexact   = 1'b1;
        end else begin
          o.word = {n.sign, e[EXP_W-1:0], m[FRAC_W-1:0]};
          o.flags.inexact = n.grd | n.stk;
        end
      end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/fpslice_ctl.sv
module fpslice_ctl
  import fpslice_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output stageCtl_t ctl,
  output logic      outValid
);
  localparam int STAGES = 3;

  logic [STAGES-1:0] vPipe;
  logic [2:0]        sinceRst;

  always_ff @(posedge clk) begin
    if (rst) begin
      vPipe    <= '0;
      outValid <= 1'b0;
    end else begin
      vPipe    <= {vPipe[STAGES-2:0], inValid};
      outValid <= vPipe[STAGES-1];
    end
  end

  assign ctl.ldIn    = inValid;
  assign ctl.ldAlign = vPipe[0];
  assign ctl.ldNorm  = vPipe[1];
  assign ctl.ldOut   = vPipe[2];

  // age of the pipeline since reset, saturating, used only by the check
  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= '0;
    else if (sinceRst != 3'd4) sinceRst <= sinceRst + 3'd1;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 3'd4) |-> (outValid == $past(inValid, 4)));
endmodule

// File: rtl/fpslice_dp.sv
module fpslice_dp
  import fpslice_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stageCtl_t         ctl,
  input  logic              cfgChainEn,
  input  logic              cfgSubtract,
  input  logic [WORD_W-1:0] mulA,
  input  logic [WORD_W-1:0] mulB,
  input  logic [WORD_W-1:0] addA,
  input  logic [WORD_W-1:0] chainIn,
  output logic [WORD_W-1:0] chainOut,
  output logic [WORD_W-1:0] result,
  output logic [3:0]        mulFlags,
  output logic [3:0]        addFlags
);
  // input register bank
  logic [WORD_W-1:0] inMulA, inMulB, inAddA, inChain;
  logic              inEn, inSub;
  // pipeline banks
  mulAlign_t mAlignNext, mAlignQ;
  addAlign_t aAlignNext, aAlignQ;
  normRec_t  mNormNext, mNormQ, aNormNext, aNormQ;
  outRec_t   mOut, aOut;

  // ---------------- multiplier: unpack, specials, significand product
  always_comb begin
    logic [MANT_W-1:0]        ma, mb;
    logic signed [XEXP_W-1:0] ea, eb;
    ma = {1'b1, fracOf(inMulA)};
    mb = {1'b1, fracOf(inMulB)};
    ea = XEXP_W'(expOf(inMulA));
    eb = XEXP_W'(expOf(inMulB));
    mAlignNext.sign = inMulA[WORD_W-1] ^ inMulB[WORD_W-1];
    mAlignNext.exp  = ea + eb - BIAS_X;
    mAlignNext.prod = PROD_W'(ma) * PROD_W'(mb);
    if (isNan(inMulA) || isNan(inMulB))
      mAlignNext.kind = K_NAN;
    else if ((isInf(inMulA) && isFlushZero(inMulB)) ||
             (isFlushZero(inMulA) && isInf(inMulB)))
      mAlignNext.kind = K_NAN;
    else if (isInf(inMulA) || isInf(inMulB))
      mAlignNext.kind = K_INF;
    else if (isFlushZero(inMulA) || isFlushZero(inMulB))
      mAlignNext.kind = K_ZERO;
    else
      mAlignNext.kind = K_NUM;
  end

  // ---------------- adder: operand swap, alignment with sticky, add
  always_comb begin
    logic [WORD_W-1:0]  opB, big, sml;
    logic               swap, effSub;
    logic [EXP_W-1:0]   d;
    logic [SH_W-1:0]    dCap;
    logic [ALIGN_W-1:0] bExt, sh;
    logic [EXT_W-1:0]   aExt, al;
    opB    = inChain ^ {inSub, {(WORD_W-1){1'b0}}};
    swap   = opB[WORD_W-2:0] > inAddA[WORD_W-2:0];
    big    = swap ? opB : inAddA;
    sml    = swap ? inAddA : opB;
    d      = expOf(big) - expOf(sml);
    dCap   = (d > EXP_W'(ALIGN_CAP)) ? SH_W'(ALIGN_CAP) : SH_W'(d);
    bExt   = {1'b1, fracOf(sml), {(ALIGN_W-MANT_W){1'b0}}};
    sh     = bExt >> dCap;
    al     = {sh[ALIGN_W-1 -: EXT_W-1], |sh[ALIGN_W-EXT_W:0]};
    aExt   = {1'b1, fracOf(big), 3'b000};
    effSub = big[WORD_W-1] ^ sml[WORD_W-1];
    aAlignNext.sum  = effSub ? ({1'b0, aExt} - {1'b0, al})
                             : ({1'b0, aExt} + {1'b0, al});
    aAlignNext.sign = big[WORD_W-1];
    aAlignNext.exp  = XEXP_W'(expOf(big));
    aAlignNext.word    = '0;
    aAlignNext.passInv = 1'b0;
    if (!inEn) begin
      aAlignNext.kind    = K_PASS;
      aAlignNext.word    = inAddA;
      aAlignNext.passInv = isSnan(inAddA);
    end else if (isNan(inAddA) || isNan(opB)) begin
      aAlignNext.kind = K_NAN;
    end else if (isInf(inAddA) && isInf(opB)) begin
      aAlignNext.kind = (inAddA[WORD_W-1] != opB[WORD_W-1]) ? K_NAN : K_INF;
      aAlignNext.sign = inAddA[WORD_W-1];
    end else if (isInf(inAddA) || isInf(opB)) begin
      aAlignNext.kind = K_INF;
      aAlignNext.sign = isInf(inAddA) ? inAddA[WORD_W-1] : opB[WORD_W-1];
    end else if (isFlushZero(inAddA) && isFlushZero(opB)) begin
      aAlignNext.kind = K_ZERO;
      aAlignNext.sign = inAddA[WORD_W-1] & opB[WORD_W-1];
    end else if (isFlushZero(inAddA)) begin
      aAlignNext.kind = K_PASS;
      aAlignNext.word = opB;
    end else if (isFlushZero(opB)) begin
      aAlignNext.kind = K_PASS;
      aAlignNext.word = inAddA;
    end else begin
      aAlignNext.kind = K_NUM;
    end
  end

  // ---------------- normalization of both units
  always_comb begin
    logic [PROD_W-1:0] p;
    p = mAlignQ.prod;
    mNormNext         = '0;
    mNormNext.kind    = mAlignQ.kind;
    mNormNext.sign    = mAlignQ.sign;
    if (p[PROD_W-1]) begin
      mNormNext.mant = p[PROD_W-1 -: MANT_W];
      mNormNext.grd  = p[PROD_W-1-MANT_W];
      mNormNext.stk  = |p[PROD_W-2-MANT_W:0];
      mNormNext.exp  = mAlignQ.exp + ONE_X;
    end else begin
      mNormNext.mant = p[PROD_W-2 -: MANT_W];
      mNormNext.grd  = p[PROD_W-2-MANT_W];
      mNormNext.stk  = |p[PROD_W-3-MANT_W:0];
      mNormNext.exp  = mAlignQ.exp;
    end
  end

  always_comb begin
    logic [SUM_W-1:0] s;
    logic [EXT_W-1:0] n;
    logic [LZ_W-1:0]  lz;
    s  = aAlignQ.sum;
    lz = lzc(s[EXT_W-1:0]);
    n  = s[EXT_W-1:0] << lz;
    aNormNext         = '0;
    aNormNext.kind    = aAlignQ.kind;
    aNormNext.sign    = aAlignQ.sign;
    aNormNext.word    = aAlignQ.word;
    aNormNext.passInv = aAlignQ.passInv;
    if (s[SUM_W-1]) begin
      aNormNext.mant = s[SUM_W-1 -: MANT_W];
      aNormNext.grd  = s[SUM_W-1-MANT_W];
      aNormNext.stk  = |s[SUM_W-2-MANT_W:0];
      aNormNext.exp  = aAlignQ.exp + ONE_X;
    end else begin
      aNormNext.mant = n[EXT_W-1 -: MANT_W];
      aNormNext.grd  = n[EXT_W-1-MANT_W];
      aNormNext.stk  = |n[EXT_W-2-MANT_W:0];
      aNormNext.exp  = aAlignQ.exp - XEXP_W'(lz);
    end
    if (aAlignQ.kind == K_NUM && s == '0) begin
      aNormNext.kind = K_ZERO;
      aNormNext.sign = 1'b0;
    end
  end

  // ---------------- rounding and packing
  always_comb begin
    mOut = finishRec(mNormQ);
    aOut = finishRec(aNormQ);
  end

  // ---------------- register banks
  always_ff @(posedge clk) begin
    if (rst) begin
      inMulA <= '0; inMulB <= '0; inAddA <= '0; inChain <= '0;
      inEn <= 1'b0; inSub <= 1'b0;
      mAlignQ <= '0; aAlignQ <= '0;
      mNormQ <= '0; aNormQ <= '0;
      chainOut <= '0; result <= '0;
      mulFlags <= '0; addFlags <= '0;
    end else begin
      if (ctl.ldIn) begin
        inMulA  <= mulA;
        inMulB  <= mulB;
        inAddA  <= addA;
        inChain <= chainIn;
        inEn    <= cfgChainEn;
        inSub   <= cfgSubtract;
      end
      if (ctl.ldAlign) begin
        mAlignQ <= mAlignNext;
        aAlignQ <= aAlignNext;
      end
      if (ctl.ldNorm) begin
        mNormQ <= mNormNext;
        aNormQ <= aNormNext;
      end
      if (ctl.ldOut) begin
        chainOut <= mOut.word;
        mulFlags <= mOut.flags;
        result   <= aOut.word;
        addFlags <= aOut.flags;
      end
    end
  end

  // ---------------- checks on the output bank
  assert_mul_nan_R6: assert property (@(posedge clk) disable iff (rst)
    mulFlags[3] |-> (chainOut == QNAN));
  assert_mul_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    mulFlags[2] |-> (chainOut[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}) && mulFlags[0]);
  assert_add_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    addFlags[2] |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}) && addFlags[0]);
  assert_mul_unf_R8: assert property (@(posedge clk) disable iff (rst)
    mulFlags[1] |-> (chainOut[WORD_W-2:0] == '0) && mulFlags[0]);
  assert_add_unf_R8: assert property (@(posedge clk) disable iff (rst)
    addFlags[1] |-> (result[WORD_W-2:0] == '0) && addFlags[0]);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ctl.ldOut |=> $stable(result) && $stable(chainOut) && $stable(addFlags));
endmodule

// File: rtl/fpslice_chain.sv
module fpslice_chain
  import fpslice_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        cfgChainEn,
  input  logic        cfgSubtract,
  input  logic [31:0] mulA,
  input  logic [31:0] mulB,
  input  logic [31:0] addA,
  input  logic [31:0] chainIn,
  output logic [31:0] chainOut,
  output logic [31:0] result,
  output logic [3:0]  mulFlags,
  output logic [3:0]  addFlags,
  output logic        outValid
);
  stageCtl_t ctl;

  fpslice_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  fpslice_dp u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .cfgChainEn  (cfgChainEn),
    .cfgSubtract (cfgSubtract),
    .mulA        (mulA),
    .mulB        (mulB),
    .addA        (addA),
    .chainIn     (chainIn),
    .chainOut    (chainOut),
    .result      (result),
    .mulFlags    (mulFlags),
    .addFlags    (addFlags)
  );
endmodule

// File: tb/fpslice_chain_bench.sv
module fpslice_chain_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        cfgChainEn = 1'b0;
  logic        cfgSubtract = 1'b0;
  logic [31:0] mulA = '0, mulB = '0, addA = '0, chainIn = '0;
  logic [31:0] chainOut, result;
  logic [3:0]  mulFlags, addFlags;
  logic        outValid;

  fpslice_chain u_fpslice_chain (
    .clk(clk), .rst(rst), .inValid(inValid),
    .cfgChainEn(cfgChainEn), .cfgSubtract(cfgSubtract),
    .mulA(mulA), .mulB(mulB), .addA(addA), .chainIn(chainIn),
    .chainOut(chainOut), .result(result),
    .mulFlags(mulFlags), .addFlags(addFlags), .outValid(outValid)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;

  logic [31:0] qC[$], qR[$];
  logic [3:0]  qMF[$], qAF[$];
  int          qCyc[$];
  string       qTag[$];

  // flag codes: {invalid, overflow, underflow, inexact}
  localparam logic [3:0] F0 = 4'b0000, FX = 4'b0001, FU = 4'b0011,
                         FO = 4'b0101, FI = 4'b1000;

  task automatic check(input bit ok, input string tag,
                       input logic [71:0] act, input logic [71:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] mA, input logic [31:0] mB,
                      input logic [31:0] aA, input logic [31:0] ch,
                      input logic en, input logic sub,
                      input logic [31:0] eC, input logic [31:0] eR,
                      input logic [3:0] eMF, input logic [3:0] eAF,
                      input string tag);
    @(negedge clk);
    inValid = 1'b1; mulA = mA; mulB = mB; addA = aA; chainIn = ch;
    cfgChainEn = en; cfgSubtract = sub;
    qC.push_back(eC); qR.push_back(eR); qMF.push_back(eMF); qAF.push_back(eAF);
    qCyc.push_back(cyc); qTag.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    mulA = 32'hDEAD_BEEF; addA = 32'h1234_5678; chainIn = 32'h4000_0000;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard and checks data, flags and latency (R5)
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (qC.size() == 0) begin
        check(1'b0, "R5 unexpected outValid", {chainOut, result, mulFlags, addFlags}, '0);
      end else begin
        logic [71:0] act, exp;
        int          issued;
        string       tag;
        act    = {chainOut, result, mulFlags, addFlags};
        exp    = {qC.pop_front(), qR.pop_front(), qMF.pop_front(), qAF.pop_front()};
        issued = qCyc.pop_front();
        tag    = $sformatf("%s latency=%0d", qTag.pop_front(), cyc - issued);
        check((act === exp) && (cyc == issued + 4), tag, act, exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && result == '0 && chainOut == '0 && mulFlags == '0 && addFlags == '0,
          "R10 reset state", {chainOut, result, mulFlags, addFlags}, '0);
    rst = 1'b0;

    // back-to-back burst
    push(32'h3FC00000, 32'h40000000, 32'h40A00000, 32'h3F800000, 0, 0,
         32'h40400000, 32'h40A00000, F0, F0, "R1 R2 mul 1.5*2, pass 5");
    push(32'h3F800000, 32'hBF800000, 32'hC0200000, 32'h7FC00000, 0, 1,
         32'hBF800000, 32'hC0200000, F0, F0, "R2 pass with subtract set");
    push(32'hBF800000, 32'h3F000000, 32'h40A00000, 32'h3F800000, 1, 0,
         32'hBF000000, 32'h40C00000, F0, F0, "R3 5+1");
    push(32'h40200000, 32'h40000000, 32'h40A00000, 32'h3F800000, 1, 1,
         32'h40A00000, 32'h40800000, F0, F0, "R4 5-1");
    push(32'h00000000, 32'h3F800000, 32'h3F800000, 32'h40400000, 1, 1,
         32'h00000000, 32'hC0000000, F0, F0, "R4 1-3 subtrahend larger");
    push(32'h80000000, 32'h3F800000, 32'h40400000, 32'hBF800000, 1, 0,
         32'h80000000, 32'h40000000, F0, F0, "R3 3+(-1)");
    idle(2);

    push(32'h3F800001, 32'h3F800001, 32'h3F800000, 32'h33800000, 1, 0,
         32'h3F800002, 32'h3F800000, FX, FX, "R9 inexact, tie to even down");
    push(32'h3F800000, 32'h3F800000, 32'h3F800001, 32'h33800000, 1, 0,
         32'h3F800000, 32'h3F800002, F0, FX, "R9 tie rounds up to even");
    push(32'h7F000000, 32'h40000000, 32'h7F7FFFFF, 32'h7F7FFFFF, 1, 0,
         32'h7F800000, 32'h7F800000, FO, FO, "R7 overflow positive");
    push(32'hFF000000, 32'h40000000, 32'hFF7FFFFF, 32'h7F7FFFFF, 1, 1,
         32'hFF800000, 32'hFF800000, FO, FO, "R7 overflow negative");
    idle(1);

    push(32'h00800000, 32'h3F000000, 32'h00800001, 32'h00800000, 1, 1,
         32'h00000000, 32'h00000000, FU, FU, "R8 underflow flush");
    push(32'h00000001, 32'h40000000, 32'h00000005, 32'h3F800000, 1, 0,
         32'h00000000, 32'h3F800000, F0, F0, "R8 subnormal operand as zero");
    push(32'h80800000, 32'h3F000000, 32'hFF800000, 32'h40000000, 1, 0,
         32'h80000000, 32'hFF800000, FU, F0, "R8 negative flush, R6 inf+finite");
    push(32'h7FC00000, 32'h3F800000, 32'h7F800000, 32'h7F800000, 1, 1,
         32'h7FC00000, 32'h7FC00000, FI, FI, "R6 NaN operand, inf-inf");
    push(32'h7F800000, 32'h00000000, 32'h7FA00000, 32'h3F800000, 1, 0,
         32'h7FC00000, 32'h7FC00000, FI, FI, "R6 inf*0, signalling NaN add");
    push(32'hFF800000, 32'h40000000, 32'h7F800001, 32'h3F800000, 0, 0,
         32'hFF800000, 32'h7F800001, F0, FI, "R2 signalling NaN passthrough, R6 -inf*2");
    push(32'h3F800000, 32'h3F800000, 32'h7FC00001, 32'h3F800000, 0, 1,
         32'h3F800000, 32'h7FC00001, F0, F0, "R2 quiet NaN passthrough");
    push(32'h80000000, 32'h80000000, 32'h3F800000, 32'h3F800000, 1, 1,
         32'h00000000, 32'h00000000, F0, F0, "R11 x-x is +0");
    push(32'h3F800000, 32'h3F800000, 32'h80000000, 32'h80000000, 1, 0,
         32'h3F800000, 32'h80000000, F0, F0, "R11 -0 + -0");
    push(32'h40400000, 32'h40400000, 32'h00000003, 32'h3F800000, 0, 0,
         32'h41100000, 32'h00000003, F0, F0, "R1 R2 3*3, subnormal passthrough");
    idle(8);

    check(qC.size() == 0, "R5 all results delivered", 72'(qC.size()), '0);

    // hold while idle
    held = result;
    idle(5);
    check(result == held && outValid == 1'b0, "R10 outputs hold while idle",
          {40'h0, result}, {40'h0, held});

    // reset clears a nonzero output bank
    check(result != '0 && chainOut != '0, "R10 outputs nonzero before reset",
          {chainOut, result, 8'h0}, {72{1'b1}});
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && result == '0 && chainOut == '0 && mulFlags == '0 && addFlags == '0,
          "R10 reset clears outputs", {chainOut, result, mulFlags, addFlags}, '0);
    rst = 1'b0;
    idle(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule